// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

This block is an asynchronous serial transmitter and receiver that a processor reaches through seven 32-bit registers on a simple single-cycle bus. Characters to send are written into an eight-entry transmit queue and shifted out one at a time. Characters that arrive on the serial input are collected into an eight-entry receive queue, and software reads them out. The frame is fixed: a low start bit, eight data bits sent least significant bit first, no parity, and one or two high stop bits. A programmable divisor sets how many clock cycles each bit lasts.

Software is not told about single events. Each queue's fill level is compared with a small programmable threshold. The two comparison results are readable and can be masked, and one interrupt line reports any unmasked result. The queue status flags sit in bit 31 of the data registers. A read of the receive data register therefore takes the character off the queue when one is present.

Top module: `uartWm`

## Requirements
- R1: After reset the transmit control, receive control, enable and divisor registers read 0, the interrupt line is low, the serial output is high and the receive data register reads 0x8000_0000.
- R2: A write to offset 0x00 queues bits 7:0 for sending. A read of offset 0x00 returns bit 31 = 1 exactly when the transmit queue holds 8 entries. A write while the queue is full is dropped.
- R3: A read of offset 0x04 returns the oldest received byte in bits 7:0 with bit 31 = 0 and removes it from the queue. When the queue is empty the read returns 0x8000_0000 and removes nothing.
- R4: A frame on the serial output is one low start bit, then data bits 0 to 7, then one high stop bit (or two when bit 1 of offset 0x08 is set). Every bit lasts DIV+1 clock cycles. A queued next frame starts right after the last stop bit.
- R5: The transmitter takes characters from its queue only while bit 0 of offset 0x08 is set. Otherwise the serial output stays high.
- R6: The receiver ignores the serial input while bit 0 of offset 0x0C is clear.
- R7: A received frame whose stop bit is low is discarded.
- R8: A character that completes while the receive queue holds 8 entries is discarded. The 8 queued entries are kept.
- R9: Pending bit 0 at offset 0x14 is 1 when the transmit level is strictly below the watermark in bits 18:16 of offset 0x08. Pending bit 1 is 1 when the receive level is strictly above the watermark in bits 18:16 of offset 0x0C.
- R10: Offset 0x10 holds the enables in bits 1:0, with the same layout as the pending bits. The interrupt line is high when any pending bit has its enable set.
- R11: The pending register at offset 0x14 is read-only. Writing to it has no effect.
- R12: The divisor at offset 0x18 reads back as written (16 bits). The control registers read back only the bits they implement: 0x0007_0003 at offset 0x08 and 0x0007_0001 at offset 0x0C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| rxLine | input | 1 | Serial input |
| txLine | output | 1 | Serial output, high when idle |
| irq | output | 1 | Combined interrupt |

## Verification
Two pairs of events can fall in the same clock edge. A bus write can add to the transmit queue at the edge where the transmitter takes its next character. A bus read can empty a receive entry at the edge where a new character lands. Both are provoked by a loopback stream: the bench refills the transmit queue whenever its full flag drops and polls the receive register without pause, so pushes and pops collide repeatedly. The result is judged by requiring the received byte sequence to equal the sent sequence exactly, with nothing lost, repeated or reordered.

// File: rtl/uartWmPkg.sv
package uartWmPkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 16;
  localparam int WM_W   = 3;

  typedef struct packed {
    logic              txPush;
    logic              rxPop;
    logic [BYTE_W-1:0] txByte;
  } strobeT;

  typedef struct packed {
    logic             txEn;
    logic             twoStop;
    logic             rxEn;
    logic [DIV_W-1:0] divisor;
  } cfgT;
endpackage

// File: rtl/syncFifo.sv
module syncFifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (level == LVL_W'(DEPTH));
  assign empty  = (level == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      level <= level + 1'b1;
      else if (doPop && !doPush) level <= level - 1'b1;
    end
  end

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (level == LVL_W'(DEPTH)));

  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && !empty) |=> (level == $past(level) - 1'b1));
endmodule

// File: rtl/uartCtrl.sv
module uartCtrl
  import uartWmPkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [4:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              txFull,
  input  logic              rxEmpty,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  output strobeT            strobes,
  output cfgT               cfg,
  output logic              irq
);
  localparam logic [2:0] IDX_TXD = 3'd0, IDX_RXD = 3'd1, IDX_TXC = 3'd2,
                         IDX_RXC = 3'd3, IDX_IEN = 3'd4, IDX_IPN = 3'd5,
                         IDX_DIV = 3'd6;
  localparam int WM_LO = 16;

  logic [2:0]       regIdx;
  logic             wrEn, rdEn;
  logic             txEnReg, twoStopReg, rxEnReg;
  logic [WM_W-1:0]  txWm, rxWm;
  logic [1:0]       ieReg, ipVec;
  logic [DIV_W-1:0] divReg;

  assign regIdx = busAddr[4:2];
  assign wrEn   = busSel && busWrite;
  assign rdEn   = busSel && !busWrite;

  assign strobes.txPush = wrEn && (regIdx == IDX_TXD);
  assign strobes.txByte = busWdata[BYTE_W-1:0];
  assign strobes.rxPop  = rdEn && (regIdx == IDX_RXD) && !rxEmpty;

  assign cfg.txEn    = txEnReg;
  assign cfg.twoStop = twoStopReg;
  assign cfg.rxEn    = rxEnReg;
  assign cfg.divisor = divReg;

  assign ipVec[0] = txLevel < LVL_W'(txWm);
  assign ipVec[1] = rxLevel > LVL_W'(rxWm);
  assign irq      = |(ipVec & ieReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEnReg <= 1'b0; twoStopReg <= 1'b0; txWm <= '0;
      rxEnReg <= 1'b0; rxWm <= '0; ieReg <= '0; divReg <= '0;
    end else if (wrEn) begin
      case (regIdx)
        IDX_TXC: begin
          txEnReg    <= busWdata[0];
          twoStopReg <= busWdata[1];
          txWm       <= busWdata[WM_LO +: WM_W];
        end
        IDX_RXC: begin
          rxEnReg <= busWdata[0];
          rxWm    <= busWdata[WM_LO +: WM_W];
        end
        IDX_IEN: ieReg  <= busWdata[1:0];
        IDX_DIV: divReg <= busWdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    busRdata = '0;
    case (regIdx)
      IDX_TXD: busRdata[31] = txFull;
      IDX_RXD: begin
        busRdata[31] = rxEmpty;
        busRdata[BYTE_W-1:0] = rxEmpty ? '0 : rxByte;
      end
      IDX_TXC: begin
        busRdata[0] = txEnReg;
        busRdata[1] = twoStopReg;
        busRdata[WM_LO +: WM_W] = txWm;
      end
      IDX_RXC: begin
        busRdata[0] = rxEnReg;
        busRdata[WM_LO +: WM_W] = rxWm;
      end
      IDX_IEN: busRdata[1:0] = ieReg;
      IDX_IPN: busRdata[1:0] = ipVec;
      IDX_DIV: busRdata[DIV_W-1:0] = divReg;
      default: ;
    endcase
  end

  // R11
  ip_readonly_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regIdx == IDX_IPN) |=> $stable(ieReg));
endmodule

// File: rtl/uartDatapath.sv
module uartDatapath
  import uartWmPkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  cfgT               cfg,
  input  logic              rxLine,
  output logic              txLine,
  output logic              txFull,
  output logic              rxEmpty,
  output logic [BYTE_W-1:0] rxByte,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel
);
  localparam int FRAME_W = BYTE_W + 3;

  logic [BYTE_W-1:0] txHead;
  logic txEmpty, rxFull, txLoad;

  // transmit side
  logic               txBusy, txTick, lastBit;
  logic [FRAME_W-1:0] txShift;
  logic [3:0]         bitsLeft;
  logic [DIV_W-1:0]   txCnt;

  assign txTick  = txBusy && (txCnt == cfg.divisor);
  assign lastBit = txTick && (bitsLeft == 4'd1);
  assign txLoad  = (!txBusy || lastBit) && cfg.txEn && !txEmpty;
  assign txLine  = txBusy ? txShift[0] : 1'b1;

  syncFifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .push(strobes.txPush), .pop(txLoad),
    .din(strobes.txByte), .dout(txHead), .level(txLevel),
    .full(txFull), .empty(txEmpty));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0; txShift <= '1; bitsLeft <= '0; txCnt <= '0;
    end else if (txLoad) begin
      txBusy   <= 1'b1;
      txShift  <= {2'b11, txHead, 1'b0};
      bitsLeft <= cfg.twoStop ? 4'(FRAME_W) : 4'(FRAME_W - 1);
      txCnt    <= '0;
    end else if (txTick) begin
      txCnt    <= '0;
      txShift  <= {1'b1, txShift[FRAME_W-1:1]};
      bitsLeft <= bitsLeft - 1'b1;
      if (bitsLeft == 4'd1) txBusy <= 1'b0;
    end else if (txBusy) begin
      txCnt <= txCnt + 1'b1;
    end
  end

  // receive side
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxStateT;
  rxStateT           rxState;
  logic              rxMeta, rxSync, rxPrev, rxPush;
  logic [DIV_W-1:0]  rxCnt;
  logic [2:0]        rxIdx;
  logic [BYTE_W-1:0] rxShift;

  syncFifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .push(rxPush), .pop(strobes.rxPop),
    .din(rxShift), .dout(rxByte), .level(rxLevel),
    .full(rxFull), .empty(rxEmpty));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1; rxSync <= 1'b1; rxPrev <= 1'b1;
      rxState <= RX_IDLE; rxCnt <= '0; rxIdx <= '0;
      rxShift <= '0; rxPush <= 1'b0;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
      rxPush <= 1'b0;
      case (rxState)
        RX_IDLE: if (cfg.rxEn && rxPrev && !rxSync) begin
          rxState <= RX_START; rxCnt <= '0;
        end
        RX_START: if (rxCnt == (cfg.divisor >> 1)) begin
          rxCnt <= '0; rxIdx <= '0;
          rxState <= rxSync ? RX_IDLE : RX_DATA;
        end else rxCnt <= rxCnt + 1'b1;
        RX_DATA: if (rxCnt == cfg.divisor) begin
          rxCnt   <= '0;
          rxShift <= {rxSync, rxShift[BYTE_W-1:1]};
          rxIdx   <= rxIdx + 1'b1;
          if (rxIdx == 3'd7) rxState <= RX_STOP;
        end else rxCnt <= rxCnt + 1'b1;
        RX_STOP: if (rxCnt == cfg.divisor) begin
          rxPush  <= rxSync;
          rxState <= RX_IDLE;
        end else rxCnt <= rxCnt + 1'b1;
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> !txLine);

  // R4
  stop_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastBit |-> txLine);

  // R3
  pop_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rxPop |-> !rxEmpty);

  // R6
  rx_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_IDLE && !cfg.rxEn) |=> (rxState == RX_IDLE));

  // R5
  tx_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txBusy && !cfg.txEn) |=> txLine);
endmodule

// File: rtl/uartWm.sv
module uartWm
  import uartWmPkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [4:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        rxLine,
  output logic        txLine,
  output logic        irq
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  strobeT            strobes;
  cfgT               cfg;
  logic              txFull, rxEmpty;
  logic [BYTE_W-1:0] rxByte;
  logic [LVL_W-1:0]  txLevel, rxLevel;

  uartCtrl #(.LVL_W(LVL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .txFull(txFull), .rxEmpty(rxEmpty), .rxByte(rxByte),
    .txLevel(txLevel), .rxLevel(rxLevel), .strobes(strobes),
    .cfg(cfg), .irq(irq));

  uartDatapath #(.FIFO_DEPTH(FIFO_DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfg(cfg),
    .rxLine(rxLine), .txLine(txLine), .txFull(txFull),
    .rxEmpty(rxEmpty), .rxByte(rxByte), .txLevel(txLevel),
    .rxLevel(rxLevel));
endmodule

// File: tb/uartWm_bench.sv
module uartWm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BITC = 4;      // DIV = 3
  localparam int WD_LIMIT = 150000;
  localparam int STREAM_N = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic rxDrv = 1'b1, loopSel = 1'b0;
  logic rxLine, txLine, irq;
  int errors = 0, checks = 0;
  logic [31:0] rd;
  int sent, rcvd, lvl;
  logic [7:0] frameBytes [2];

  assign rxLine = loopSel ? txLine : rxDrv;

  always #(CLK_PERIOD/2) clk = ~clk;

  uartWm u_uartWm (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rxLine(rxLine), .txLine(txLine), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input logic stopVal);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      rxDrv = (k == 0) ? 1'b0 : (k == 9) ? stopVal : b[k-1];
      repeat (BITC - 1) @(negedge clk);
    end
    @(negedge clk); rxDrv = 1'b1;
    repeat (3 * BITC) @(negedge clk);
  endtask

  // R4: sample first frame mid-bit and the start of the next frame
  task automatic checkFrame(input logic [7:0] b, input int nb);
    logic expBit;
    @(negedge clk);
    while (txLine !== 1'b0) @(negedge clk);
    for (int c = 0; c < nb * BITC; c++) begin
      if (c % BITC == 2) begin
        expBit = (c / BITC == 0) ? 1'b0 : (c / BITC <= 8) ? b[c/BITC-1] : 1'b1;
        check("R4 frame bit", {31'b0, txLine}, {31'b0, expBit});
      end
      @(negedge clk);
    end
    check("R4 back-to-back start", {31'b0, txLine}, 32'd0);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    busRd(5'h08, rd); check("R1 txctrl", rd, 0);
    busRd(5'h0C, rd); check("R1 rxctrl", rd, 0);
    busRd(5'h10, rd); check("R1 ie", rd, 0);
    busRd(5'h18, rd); check("R1 div", rd, 0);
    busRd(5'h04, rd); check("R1 rxdata empty", rd, 32'h8000_0000);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 txLine", {31'b0, txLine}, 1);

    // R12 readback masks
    busWr(5'h18, 32'hFFFF_1234); busRd(5'h18, rd); check("R12 div", rd, 32'h1234);
    busWr(5'h08, 32'hFFFF_FFFF); busRd(5'h08, rd); check("R12 txctrl", rd, 32'h0007_0003);
    busWr(5'h0C, 32'hFFFF_FFFF); busRd(5'h0C, rd); check("R12 rxctrl", rd, 32'h0007_0001);
    busWr(5'h10, 32'hFFFF_FFFF); busRd(5'h10, rd); check("R10 ie readback", rd, 3);
    busWr(5'h10, 0); busWr(5'h08, 0); busWr(5'h0C, 0);
    busWr(5'h18, BITC - 1);

    // R9 transmit watermark sweep, R2 full flag and drop, R5 disabled
    for (int l = 0; l <= 8; l++) begin
      for (int w = 0; w < 8; w++) begin
        busWr(5'h08, w << 16);
        busRd(5'h14, rd);
        check("R9 tx pending", {31'b0, rd[0]}, {31'b0, (l < w)});
      end
      busRd(5'h00, rd);
      check("R2 full flag", {31'b0, rd[31]}, {31'b0, (l == 8)});
      busWr(5'h00, 32'h140 + l);
    end
    check("R5 line idle while disabled", {31'b0, txLine}, 1);
    busWr(5'h08, 32'h0001_0000);
    busWr(5'h10, 1);
    check("R10 irq masked on", {31'b0, irq}, 0);
    busWr(5'h08, 32'h0002_0000);
    @(negedge clk);
    check("R10 irq off at full level", {31'b0, irq}, 0);
    busWr(5'h10, 0);

    // drain through loopback: expect exactly 8 bytes
    loopSel = 1'b1;
    busWr(5'h0C, 1); busWr(5'h08, 1);
    repeat (10 * BITC * 9 + 50) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      busRd(5'h04, rd); check("R2 R3 queued byte", rd, 32'h40 + k);
    end
    busRd(5'h04, rd); check("R2 dropped write", rd, 32'h8000_0000);

    // R4 one and two stop bits
    for (int ts = 0; ts < 2; ts++) begin
      busWr(5'h08, ts << 1);
      frameBytes[0] = (ts == 0) ? 8'hA5 : 8'h5A;
      frameBytes[1] = (ts == 0) ? 8'h3C : 8'hC3;
      busWr(5'h00, frameBytes[0]); busWr(5'h00, frameBytes[1]);
      busWr(5'h08, 1 | (ts << 1));
      checkFrame(frameBytes[0], 10 + ts);
      repeat (12 * BITC + 20) @(negedge clk);
      busRd(5'h04, rd); check("R3 loopback first", rd, frameBytes[0]);
      busRd(5'h04, rd); check("R3 loopback second", rd, frameBytes[1]);
    end
    busWr(5'h08, 1);

    // stream: transmit push vs dequeue, receive push vs pop
    sent = 0; rcvd = 0;
    while (rcvd < STREAM_N) begin
      busRd(5'h04, rd);
      if (!rd[31]) begin
        check("R3 stream order", rd, (rcvd * 37 + 11) & 8'hFF);
        rcvd++;
      end
      busRd(5'h00, rd);
      if (!rd[31] && sent < STREAM_N) begin
        busWr(5'h00, (sent * 37 + 11) & 8'hFF);
        sent++;
      end
    end

    // R6 receiver disabled
    loopSel = 1'b0;
    busWr(5'h0C, 0);
    sendByte(8'h77, 1'b1);
    busRd(5'h04, rd); check("R6 ignored when off", rd, 32'h8000_0000);

    // R7 low stop bit
    busWr(5'h0C, 1);
    sendByte(8'h66, 1'b0);
    busRd(5'h04, rd); check("R7 bad stop dropped", rd, 32'h8000_0000);
    sendByte(8'h99, 1'b1);
    busRd(5'h04, rd); check("R7 good frame after", rd, 32'h99);

    // R9 receive watermark sweep, R8 overflow
    for (int f = 0; f <= 9; f++) begin
      lvl = (f > 8) ? 8 : f;
      for (int w = 0; w < 8; w++) begin
        busWr(5'h0C, (w << 16) | 1);
        busRd(5'h14, rd);
        check("R9 rx pending", {31'b0, rd[1]}, {31'b0, (lvl > w)});
      end
      if (f < 9) sendByte(8'h30 + f, 1'b1);
    end
    busWr(5'h0C, 1);
    busWr(5'h10, 2);
    @(negedge clk);
    check("R10 irq rx", {31'b0, irq}, 1);
    busWr(5'h10, 1);
    @(negedge clk);
    check("R10 irq rx masked", {31'b0, irq}, 0);
    busWr(5'h10, 0);
    for (int k = 0; k < 8; k++) begin
      busRd(5'h04, rd); check("R8 kept entry", rd, 32'h30 + k);
    end
    busRd(5'h04, rd); check("R8 overflow discarded", rd, 32'h8000_0000);

    // R11 pending read-only
    busWr(5'h08, 32'h0002_0000);
    busWr(5'h14, 32'hFFFF_FFFF);
    busRd(5'h14, rd); check("R11 ip after write ones", rd, 1);
    busWr(5'h14, 0);
    busRd(5'h14, rd); check("R11 ip after write zero", rd, 1);
    busRd(5'h10, rd); check("R11 ie untouched", rd, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule